// File: doc/BRIEF.md
# Cipher Key Register Bank with Zeroization

This block holds the secret key used by a block-cipher datapath: up to 256 bits, kept as eight 32-bit word slots. Software or a sequencer loads the slots one word at a time. Each word has its byte order reversed on the way in, so a little-endian bus word becomes the big-endian layout the cipher expects. A separate commit command sets the active key length to 128 or 256 bits. A zeroize command wipes every key bit and raises a status flag, and a later valid commit lowers that flag again.

The key, the committed length and the zeroized status drive the cipher datapath continuously. Commands change state only while the engine reports idle. A command that arrives while the engine is busy, or that carries a bad address or length, leaves all state unchanged and produces a one-cycle error pulse. When several commands arrive in the same cycle, a fixed priority decides which one is acted on.

Top module: `aes_key_bank`

## Requirements
- R1: An accepted write stores `wr_data` with its four bytes reversed (bits 7:0 move to 31:24, bits 15:8 to 23:16, and so on) into slot `wr_addr`. Slot n appears on `key_o[32n+31:32n]` from the next cycle.
- R2: A write whose `wr_addr` is 8 to 15 changes no slot and raises `err_o`.
- R3: An accepted commit with `commit_len` equal to 128 or 256 sets `key_len_o` to that value and clears `key_zeroed_o` in the next cycle. The key words are not changed.
- R4: A commit with any other `commit_len` changes neither `key_len_o` nor `key_zeroed_o` and raises `err_o`.
- R5: An accepted zeroize sets all 256 bits of `key_o` to 0 and sets `key_zeroed_o` in the next cycle.
- R6: While `idle_i` is low, a write, commit or zeroize changes no output other than `err_o`, and raises `err_o`.
- R7: `err_o` is high in exactly the cycle after each rejected command and low in every other cycle.
- R8: When more than one command is asserted in a cycle, only the highest-priority one is evaluated: zeroize first, then commit, then write. The others are dropped without error.
- R9: After reset, `key_o` is 0, `key_zeroed_o` is 0, `key_len_o` is 256 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | Cipher engine reports idle; commands are accepted only while it is high |
| wr_en | input | 1 | Write one key word |
| wr_addr | input | 4 | Word slot index; 0 to 7 are valid |
| wr_data | input | 32 | Word to store, before byte reversal |
| commit_en | input | 1 | Commit key length |
| commit_len | input | 9 | Requested key length in bits |
| zero_en | input | 1 | Zeroize command |
| key_o | output | 256 | Key; slot n in bits 32n+31:32n |
| key_len_o | output | 9 | Committed key length (128 or 256) |
| key_zeroed_o | output | 1 | Key has been wiped since the last valid commit |
| err_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
Each slot is first written with a distinct asymmetric word. A byte-order fault or an addressing fault then shows up in a specific lane of `key_o`. Commits with 128 and 256 are mixed with illegal lengths such as 0, 192 and 511, which tells a missing length check apart from a correct one. The same write, commit and zeroize patterns are then repeated with `idle_i` low and with several commands in one cycle, to separate gating faults from priority faults. Back-to-back rejected commands show whether the error pulse is counted per command or stretched. A long random phase then runs every command against the reference model.

// File: rtl/aes_key_bank.sv
module aes_key_bank #(
  parameter int WORDS = 8,
  parameter int WW    = 32,
  parameter int AW    = 4,
  parameter int LW    = 9,
  parameter int LEN_S = 128,
  parameter int LEN_L = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle_i,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [WW-1:0]       wr_data,
  input  logic                commit_en,
  input  logic [LW-1:0]       commit_len,
  input  logic                zero_en,
  output logic [WORDS*WW-1:0] key_o,
  output logic [LW-1:0]       key_len_o,
  output logic                key_zeroed_o,
  output logic                err_o
);
  localparam int SW = $clog2(WORDS);
  localparam int NB = WW / 8;

  logic [WW-1:0] key_q [WORDS];
  logic [WW-1:0] swapped;
  logic          sel_zero, sel_commit, sel_wr;
  logic          addr_ok, len_ok;
  logic          acc_zero, acc_commit, acc_wr, reject;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_swap
      assign swapped[8*b +: 8] = wr_data[8*(NB-1-b) +: 8];
    end
  endgenerate

  assign sel_zero   = zero_en;
  assign sel_commit = commit_en & ~zero_en;
  assign sel_wr     = wr_en & ~zero_en & ~commit_en;

  assign addr_ok = int'(wr_addr) < WORDS;
  assign len_ok  = (commit_len == LW'(LEN_S)) || (commit_len == LW'(LEN_L));

  assign acc_zero   = idle_i & sel_zero;
  assign acc_commit = idle_i & sel_commit & len_ok;
  assign acc_wr     = idle_i & sel_wr & addr_ok;
  assign reject     = (sel_zero | sel_commit | sel_wr) & ~(acc_zero | acc_commit | acc_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) key_q[i] <= '0;
      key_len_o    <= LW'(LEN_L);
      key_zeroed_o <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      err_o <= reject;
      if (acc_zero) begin
        for (int i = 0; i < WORDS; i++) key_q[i] <= '0;
        key_zeroed_o <= 1'b1;
      end else if (acc_commit) begin
        key_len_o    <= commit_len;
        key_zeroed_o <= 1'b0;
      end else if (acc_wr) begin
        key_q[wr_addr[SW-1:0]] <= swapped;
      end
    end
  end

  genvar w;
  generate
    for (w = 0; w < WORDS; w++) begin : g_out
      assign key_o[WW*w +: WW] = key_q[w];
    end
  endgenerate

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> ($stable(key_o) && $stable(key_len_o) && $stable(key_zeroed_o)));

  // R5
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && zero_en) |=> (key_o == '0 && key_zeroed_o));

  // R3
  commit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && commit_en && !zero_en &&
     (commit_len == LW'(LEN_S) || commit_len == LW'(LEN_L)))
    |=> (!key_zeroed_o && key_len_o == $past(commit_len)));

  // R4
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_len_o == LW'(LEN_S) || key_len_o == LW'(LEN_L)));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(wr_en || commit_en || zero_en));
endmodule

// File: tb/tb_aes_key_bank.sv
module tb_aes_key_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         idle_i = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         commit_en = 1'b0;
  logic [8:0]   commit_len = '0;
  logic         zero_en = 1'b0;
  logic [255:0] key_o;
  logic [8:0]   key_len_o;
  logic         key_zeroed_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mk [8];
  int          mlen;
  bit          mz;
  bit          merr;

  always #10 clk = ~clk;

  aes_key_bank dut (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_en(commit_en), .commit_len(commit_len), .zero_en(zero_en),
    .key_o(key_o), .key_len_o(key_len_o), .key_zeroed_o(key_zeroed_o),
    .err_o(err_o)
  );

  function automatic logic [255:0] model_key();
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[32*i +: 32] = mk[i];
    return k;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (key_o !== model_key()) begin
      errors++;
      $display("FAIL %s key actual=%h expected=%h", tag, key_o, model_key());
    end
    checks++;
    if (key_len_o !== 9'(mlen)) begin
      errors++;
      $display("FAIL %s len actual=%0d expected=%0d", tag, key_len_o, mlen);
    end
    checks++;
    if (key_zeroed_o !== mz) begin
      errors++;
      $display("FAIL %s zeroed actual=%0b expected=%0b", tag, key_zeroed_o, mz);
    end
    checks++;
    if (err_o !== merr) begin
      errors++;
      $display("FAIL %s err actual=%0b expected=%0b", tag, err_o, merr);
    end
  endtask

  // Behavioural reference: priority zeroize, commit, write; all gated by idle.
  task automatic model_step();
    bit bad = 1'b0;
    if (zero_en) begin
      if (idle_i) begin
        for (int i = 0; i < 8; i++) mk[i] = 32'h0;
        mz = 1'b1;
      end else bad = 1'b1;
    end else if (commit_en) begin
      if (idle_i && (commit_len == 9'd128 || commit_len == 9'd256)) begin
        mlen = int'(commit_len);
        mz = 1'b0;
      end else bad = 1'b1;
    end else if (wr_en) begin
      if (idle_i && wr_addr < 4'd8)
        mk[wr_addr[2:0]] = {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};
      else bad = 1'b1;
    end
    merr = bad;
  endtask

  task automatic step(input bit idl, input bit we, input logic [3:0] a, input logic [31:0] d,
                      input bit ce, input logic [8:0] l, input bit ze, input string tag);
    idle_i = idl; wr_en = we; wr_addr = a; wr_data = d;
    commit_en = ce; commit_len = l; zero_en = ze;
    @(posedge clk);
    #1;
    model_step();
    compare(tag);
    #8;
  endtask

  task automatic idle_cycle(input string tag);
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 9'd0, 1'b0, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mk[i] = 32'h0;
    mlen = 256; mz = 1'b0; merr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    compare("R9 reset");
    rst_n = 1'b1;
    #8;
    idle_cycle("R9 after reset");

    for (int i = 0; i < 8; i++)
      step(1'b1, 1'b1, 4'(i), 32'h11223344 + 32'(i) * 32'h01020304, 1'b0, 9'd0, 1'b0, "R1 write");
    step(1'b1, 1'b1, 4'd3, 32'hA1B2C3D4, 1'b0, 9'd0, 1'b0, "R1 overwrite");

    step(1'b1, 1'b1, 4'd8, 32'hDEADBEEF, 1'b0, 9'd0, 1'b0, "R2 addr 8");
    step(1'b1, 1'b1, 4'd15, 32'hCAFEF00D, 1'b0, 9'd0, 1'b0, "R2 addr 15 R7 back-to-back");
    idle_cycle("R7 pulse ends");

    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd128, 1'b0, "R3 commit 128");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd192, 1'b0, "R4 commit 192");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd0, 1'b0, "R4 commit 0");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd511, 1'b0, "R4 commit 511");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd256, 1'b0, "R3 commit 256");

    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b0, 9'd0, 1'b1, "R5 zeroize");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd100, 1'b0, "R4 bad commit keeps zeroed");
    step(1'b1, 1'b1, 4'd5, 32'h01234567, 1'b0, 9'd0, 1'b0, "R1 write after zeroize");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd128, 1'b0, "R3 commit clears zeroed");

    step(1'b0, 1'b1, 4'd2, 32'h55AA55AA, 1'b0, 9'd0, 1'b0, "R6 busy write");
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 9'd256, 1'b0, "R6 busy commit");
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 9'd0, 1'b1, "R6 busy zeroize");
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 9'd0, 1'b0, "R7 busy no command");

    step(1'b1, 1'b1, 4'd1, 32'h87654321, 1'b1, 9'd256, 1'b0, "R8 commit over write");
    step(1'b1, 1'b1, 4'd9, 32'h87654321, 1'b1, 9'd128, 1'b0, "R8 bad write dropped");
    step(1'b1, 1'b1, 4'd0, 32'hFFFF0000, 1'b1, 9'd7, 1'b1, "R8 zeroize over all");
    step(1'b1, 1'b0, 4'd0, 32'h0, 1'b1, 9'd77, 1'b0, "R8 R4 bad commit alone");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2] | r[3], r[7:4], $urandom, r[8] & r[9],
           r[10] ? (r[11] ? 9'd128 : 9'd256) : r[20:12], r[21] & r[22] & r[23],
           "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule